// File: doc/BRIEF.md
# Scanned Keyboard Controller with Key FIFO

The block walks a key matrix one row at a time, looks at the return columns of the active row, and accepts a key only after the key stays closed through a debounce window. Each accepted key becomes one byte. The byte holds the row, the column and the state of the shift and control inputs. It goes into an eight-entry first-in-first-out queue. A host reads these bytes, and a status byte, through a small bus with one address bit, a chip select and active-low read and write strobes. The interrupt line stays high while the queue holds key bytes.

The scan lines work in one of two ways. In binary mode they carry the row number for an external decoder, which gives up to eight rows of eight keys. In one-hot mode the block itself decodes the row into four separate lines, which gives four rows of eight keys. A programmable prescaler sets how many clocks each row stays active. When the queue is full, a new key sets a sticky overrun flag and the scan keeps running.

Top module: `kbd_scan_ctrl`

## Requirements
- R1: After reset the scan row is 0 in binary mode, the queue is empty, irq_o is low, the status byte reads 0x00 and the prescaler value is 3.
- R2: In binary mode scan_o[2:0] carries the row number and scan_o[3] is 0. The row steps by one every prescaler+1 clocks and wraps from 7 to 0.
- R3: In one-hot mode exactly one of the four scan lines is high, line k for row k. The row steps through 0..3 and wraps.
- R4: A closure is first seen on a visit to its row. It is stored only if the same key is still closed on the second later visit to that row. A closure that ends earlier stores nothing.
- R5: The key byte is: bit 7 control, bit 6 shift, bits 5:3 row, bits 2:0 column. When several columns of one row are closed, the lowest-numbered one is used. Shift and control are taken in the clock where the key is accepted.
- R6: A key held down is stored once. It can be stored again only after a visit to its row finds it open.
- R7: A read with a0_i=0 returns the oldest queued byte. The byte leaves the queue when the read strobe ends. Bytes come out in the order the keys were accepted.
- R8: A read with a0_i=1 returns status: bits 3:0 hold the entry count, bit 5 the overrun flag, and the other bits are 0. Reading status does not change the queue.
- R9: A key accepted while 8 entries are held is dropped, the held entries stay as they are, and the overrun flag is set. The scan keeps running. Writing a command byte with bit 7 set clears the flag.
- R10: irq_o is high while the queue holds an entry and no queue read strobe is active. It is low while such a strobe is active and comes back after the strobe ends if entries remain.
- R11: A write with a0_i=1 loads a command. Bit 0 selects one-hot mode (1) or binary mode (0). The write restarts the scan at row 0 and drops any key in progress. A write with a0_i=0 loads the prescaler. A write while cs_ni is high has no effect.
- R12: A queue read when the queue is empty returns 0x00 and leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| a0_i | input | 1 | Address: 0 selects queue/prescaler, 1 selects status/command |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, 0 when no read is active |
| scan_o | output | 4 | Scan lines (binary row or one-hot) |
| ret_i | input | 8 | Return columns, 1 = key closed in the active row |
| shift_i | input | 1 | Shift key state |
| ctrl_i | input | 1 | Control key state |
| irq_o | output | 1 | Key-available interrupt |

## Verification
A behavioural keyboard drives the return lines from the scan lines. It is stimulated with single keys held long enough, with closures too short to pass the debounce window, with one key held for many scan cycles, and with several columns closed at once in one row. These cases separate a proper debounce from a plain edge detector, and they show a repeating key and the column priority. Runs of distinct keys in both scan modes test the queue order. A run of nine keys against an unread queue shows whether an overflow drops the new key and leaves the old entries intact. Reads of status and data, done while keys are pending, show that a status read does not pop an entry and that the interrupt drops for the length of each data read.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef enum logic [1:0] {
    DB_IDLE = 2'd0,
    DB_WAIT = 2'd1,
    DB_HELD = 2'd2
  } db_state_e;

  localparam int unsigned STAT_OVR_BIT = 5;
  localparam int unsigned CMD_MODE_BIT = 0;
  localparam int unsigned CMD_CLR_BIT  = 7;
  localparam int unsigned DB_VISITS    = 2;
endpackage

// File: rtl/kbd_host_if.sv
module kbd_host_if #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PRESC_W   = 8,
  parameter int unsigned PRESC_RST = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic               a0_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               rd_act_o,
  output logic               fifo_rd_o,
  output logic               pop_o,
  output logic               decoded_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic               mode_wr_o,
  output logic               presc_wr_o,
  output logic               ovr_clr_o
);
  import kbd_pkg::*;

  logic wr_act, wr_q, wr_stb, fifo_rd_q;

  assign rd_act_o  = !cs_ni && !rd_ni;
  assign fifo_rd_o = rd_act_o && !a0_i;
  assign wr_act    = !cs_ni && !wr_ni;
  assign wr_stb    = wr_act && !wr_q;

  assign pop_o      = fifo_rd_q && !fifo_rd_o;
  assign mode_wr_o  = wr_stb && a0_i;
  assign presc_wr_o = wr_stb && !a0_i;
  assign ovr_clr_o  = mode_wr_o && data_i[CMD_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b0;
      fifo_rd_q <= 1'b0;
      decoded_o <= 1'b0;
      presc_o   <= PRESC_W'(PRESC_RST);
    end else begin
      wr_q      <= wr_act;
      fifo_rd_q <= fifo_rd_o;
      if (mode_wr_o)  decoded_o <= data_i[CMD_MODE_BIT];
      if (presc_wr_o) presc_o   <= data_i[PRESC_W-1:0];
    end
  end

  AST_POP_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> $past(!cs_ni && !rd_ni && !a0_i)); // R7
  AST_NO_WRITE_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(decoded_o) && $stable(presc_o)); // R11
endmodule

// File: rtl/kbd_scan.sv
module kbd_scan #(
  parameter int unsigned ROW_W   = 3,
  parameter int unsigned PRESC_W = 8,
  parameter int unsigned SCAN_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               decoded_i,
  input  logic               restart_i,
  input  logic               presc_wr_i,
  output logic               tick_o,
  output logic [ROW_W-1:0]   row_o,
  output logic [SCAN_W-1:0]  scan_o
);
  localparam logic [ROW_W-1:0] LAST_ENC = ROW_W'((1 << ROW_W) - 1);
  localparam logic [ROW_W-1:0] LAST_DEC = ROW_W'(3);

  logic [PRESC_W-1:0] pc_q;
  logic [ROW_W-1:0]   row_q, last_row;

  assign tick_o   = (pc_q == presc_i);
  assign last_row = decoded_i ? LAST_DEC : LAST_ENC;
  assign row_o    = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      row_q <= '0;
    end else begin
      if (presc_wr_i || tick_o) pc_q <= '0;
      else                      pc_q <= pc_q + 1'b1;
      if (restart_i)            row_q <= '0;
      else if (tick_o)          row_q <= (row_q >= last_row) ? '0 : row_q + 1'b1;
    end
  end

  always_comb begin
    scan_o = '0;
    if (decoded_i) scan_o[row_q[1:0]] = 1'b1;
    else           scan_o[ROW_W-1:0]  = row_q;
  end

  AST_DEC_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decoded_i |-> $countones(scan_o) == 1); // R3
  AST_DEC_ROW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decoded_i && !restart_i && tick_o && row_q <= LAST_DEC |=> row_q <= LAST_DEC); // R3
  AST_ROW_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && !restart_i |=> row_q != $past(row_q)); // R2
  AST_ROW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o && !restart_i |=> $stable(row_q)); // R2
endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce #(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned COL_N = 8,
  parameter int unsigned COL_W = 3,
  parameter int unsigned CODE_W = 2 + ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_N-1:0]  ret_i,
  input  logic              shift_i,
  input  logic              ctrl_i,
  output logic              push_o,
  output logic [CODE_W-1:0] code_o
);
  import kbd_pkg::*;

  localparam logic [1:0] LAST_VISIT = 2'(DB_VISITS - 1);

  db_state_e        st_q, st_d;
  logic [ROW_W-1:0] crow_q, crow_d;
  logic [COL_W-1:0] ccol_q, ccol_d;
  logic [1:0]       vis_q, vis_d;
  logic             push;

  function automatic logic [COL_W-1:0] low_col(input logic [COL_N-1:0] v);
    logic [COL_W-1:0] r;
    r = '0;
    for (int i = COL_N - 1; i >= 0; i--) if (v[i]) r = COL_W'(i);
    return r;
  endfunction

  always_comb begin
    st_d   = st_q;
    crow_d = crow_q;
    ccol_d = ccol_q;
    vis_d  = vis_q;
    push   = 1'b0;
    if (tick_i) begin
      unique case (st_q)
        DB_IDLE: if (|ret_i) begin
          crow_d = row_i;
          ccol_d = low_col(ret_i);
          vis_d  = '0;
          st_d   = DB_WAIT;
        end
        DB_WAIT: if (row_i == crow_q) begin
          if (ret_i[ccol_q]) begin
            vis_d = vis_q + 1'b1;
            if (vis_q == LAST_VISIT) begin
              push = 1'b1;
              st_d = DB_HELD;
            end
          end else begin
            st_d = DB_IDLE;
          end
        end
        DB_HELD: if (row_i == crow_q && !ret_i[ccol_q]) st_d = DB_IDLE;
        default: st_d = DB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= DB_IDLE;
      crow_q <= '0;
      ccol_q <= '0;
      vis_q  <= '0;
    end else begin
      st_q   <= restart_i ? DB_IDLE : st_d;
      crow_q <= crow_d;
      ccol_q <= ccol_d;
      vis_q  <= vis_d;
    end
  end

  assign push_o = push && !restart_i;
  assign code_o = {ctrl_i, shift_i, crow_q, ccol_q};

  AST_PUSH_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> tick_i && ret_i[ccol_q] && row_i == crow_q); // R4
  AST_PUSH_THEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> st_q == DB_HELD); // R6
  AST_HELD_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == DB_HELD |-> !push_o); // R6
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  input  logic          ovr_clr_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          ovr_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && (cnt_q != '0);
  assign head_o  = (cnt_q != '0) ? mem[rp_q] : '0;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_o <= 1'b0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && full) ovr_o <= 1'b1;
      else if (ovr_clr_i) ovr_o <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R9
  AST_OVR_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full |=> ovr_o); // R9
  AST_FULL_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full && !pop_i |=> $stable(cnt_q)); // R9
  AST_POP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1); // R7
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && cnt_q == '0 |=> cnt_q == '0); // R12
endmodule

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl #(
  parameter int unsigned ROW_W     = 3,
  parameter int unsigned COL_N     = 8,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned PRESC_W   = 8,
  parameter int unsigned PRESC_RST = 3,
  parameter int unsigned COL_W     = $clog2(COL_N),
  parameter int unsigned CODE_W    = 2 + ROW_W + COL_W,
  parameter int unsigned SCAN_W    = (ROW_W > 4) ? ROW_W : 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              a0_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] data_o,
  output logic [SCAN_W-1:0] scan_o,
  input  logic [COL_N-1:0]  ret_i,
  input  logic              shift_i,
  input  logic              ctrl_i,
  output logic              irq_o
);
  import kbd_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic               rd_act, fifo_rd, pop, decoded, mode_wr, presc_wr, ovr_clr;
  logic               tick, push, ovr;
  logic [PRESC_W-1:0] presc;
  logic [ROW_W-1:0]   row;
  logic [CODE_W-1:0]  code, head, status;
  logic [CW-1:0]      count;

  kbd_host_if #(.DATA_W(CODE_W), .PRESC_W(PRESC_W), .PRESC_RST(PRESC_RST)) u_host (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .a0_i, .data_i,
    .rd_act_o(rd_act), .fifo_rd_o(fifo_rd), .pop_o(pop), .decoded_o(decoded),
    .presc_o(presc), .mode_wr_o(mode_wr), .presc_wr_o(presc_wr), .ovr_clr_o(ovr_clr)
  );

  kbd_scan #(.ROW_W(ROW_W), .PRESC_W(PRESC_W), .SCAN_W(SCAN_W)) u_scan (
    .clk_i, .rst_ni, .presc_i(presc), .decoded_i(decoded), .restart_i(mode_wr),
    .presc_wr_i(presc_wr), .tick_o(tick), .row_o(row), .scan_o(scan_o)
  );

  kbd_debounce #(.ROW_W(ROW_W), .COL_N(COL_N), .COL_W(COL_W), .CODE_W(CODE_W)) u_db (
    .clk_i, .rst_ni, .tick_i(tick), .restart_i(mode_wr), .row_i(row), .ret_i,
    .shift_i, .ctrl_i, .push_o(push), .code_o(code)
  );

  kbd_fifo #(.DEPTH(DEPTH), .W(CODE_W), .CW(CW)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .din_i(code), .pop_i(pop), .ovr_clr_i(ovr_clr),
    .head_o(head), .count_o(count), .ovr_o(ovr)
  );

  always_comb begin
    status               = '0;
    status[CW-1:0]       = count;
    status[STAT_OVR_BIT] = ovr;
  end

  assign data_o = !rd_act ? '0 : (a0_i ? status : head);
  assign irq_o  = (count != '0) && !fifo_rd;

  AST_IRQ_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count == '0 |-> !irq_o); // R10
  AST_IRQ_READ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni && !rd_ni && !a0_i |-> !irq_o); // R10
  AST_STATUS_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni && !rd_ni && a0_i && !push |=> count == $past(count)); // R8
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni |-> data_o == '0); // R12
endmodule

// File: tb/tb_kbd_scan_ctrl.sv
module tb_kbd_scan_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
  logic [7:0] din = 8'h00, dout, ret;
  logic [3:0] scan;
  logic       shift = 1'b0, ctrl = 1'b0, irq;
  logic [7:0] keys [8];
  logic       kb_dec = 1'b0;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  kbd_scan_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n), .a0_i(a0),
    .data_i(din), .data_o(dout), .scan_o(scan), .ret_i(ret), .shift_i(shift),
    .ctrl_i(ctrl), .irq_o(irq)
  );

  // keyboard: external decoder in binary mode, direct lines in one-hot mode
  always_comb begin
    ret = 8'h00;
    if (kb_dec) begin
      for (int k = 0; k < 4; k++) if (scan[k]) ret = ret | keys[k];
    end else begin
      ret = keys[scan[2:0]];
    end
  end

  // reference model
  int         m_row, m_pc, m_presc, m_st, m_vis, m_crow, m_ccol;
  bit         m_dec, m_ovr, m_rdq, m_wrq;
  logic [7:0] m_q [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_row = 0; m_pc = 0; m_presc = 3; m_st = 0; m_vis = 0; m_crow = 0; m_ccol = 0;
      m_dec = 0; m_ovr = 0; m_rdq = 0; m_wrq = 0; m_q.delete();
    end else begin
      bit rd_f, wr_a, wstb, pop, push, tick, mwr, pwr, full;
      logic [7:0] mret, code;
      rd_f = !cs_n && !rd_n && !a0;
      wr_a = !cs_n && !wr_n;
      wstb = wr_a && !m_wrq;
      mwr  = wstb && a0;
      pwr  = wstb && !a0;
      pop  = m_rdq && !rd_f && (m_q.size() > 0);
      tick = (m_pc == m_presc);
      mret = keys[m_row];
      push = 0; code = 8'h00;
      if (tick && !mwr) begin
        case (m_st)
          0: if (mret != 0) begin
               m_crow = m_row; m_vis = 0; m_st = 1;
               for (int c = 7; c >= 0; c--) if (mret[c]) m_ccol = c;
             end
          1: if (m_row == m_crow) begin
               if (mret[m_ccol]) begin
                 m_vis++;
                 if (m_vis == 2) begin
                   push = 1; m_st = 2;
                   code = {ctrl, shift, 3'(m_crow), 3'(m_ccol)};
                 end
               end else m_st = 0;
             end
          default: if (m_row == m_crow && !mret[m_ccol]) m_st = 0;
        endcase
      end
      if (mwr) m_st = 0;
      full = (m_q.size() == 8);
      if (pop) void'(m_q.pop_front());
      if (push) begin
        if (full) m_ovr = 1;
        else m_q.push_back(code);
      end else if (mwr && din[7]) m_ovr = 0;
      if (mwr) m_row = 0;
      else if (tick) m_row = (m_row >= (m_dec ? 3 : 7)) ? 0 : m_row + 1;
      if (pwr || tick) m_pc = 0; else m_pc++;
      if (mwr) m_dec = din[0];
      if (pwr) m_presc = din;
      m_rdq = rd_f;
      m_wrq = wr_a;
    end
  end

  task automatic cmp(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%02h expected=%02h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {2'b00, m_ovr, 1'b0, 4'(m_q.size())};
  endfunction

  // cycle-by-cycle comparison, away from the edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      logic [3:0] es;
      logic [7:0] ed;
      bit rd_a;
      es = m_dec ? 4'(1 << m_row) : {1'b0, 3'(m_row)};
      rd_a = !cs_n && !rd_n;
      ed = !rd_a ? 8'h00 : (a0 ? m_status() : (m_q.size() > 0 ? m_q[0] : 8'h00));
      cmp(m_dec ? "R3" : "R2", "scan_o", {4'h0, scan}, {4'h0, es});
      cmp("R10", "irq_o", {7'h0, irq}, {7'h0, (m_q.size() > 0) && !(rd_a && !a0)});
      cmp(a0 ? "R8" : "R7", "data_o", dout, ed);
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(bit a, logic [7:0] d, bit sel = 1);
    @(negedge clk);
    cs_n = !sel; wr_n = 0; a0 = a; din = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1; din = 8'h00;
  endtask

  task automatic bus_rd(bit a, output logic [7:0] d, output logic i);
    @(negedge clk);
    cs_n = 0; rd_n = 0; a0 = a;
    @(posedge clk); #1;
    d = dout; i = irq;
    @(negedge clk);
    cs_n = 1; rd_n = 1; a0 = 0;
  endtask

  task automatic press(int r, int c, bit sh, bit ct, int hold, int gap);
    @(negedge clk);
    shift = sh; ctrl = ct; keys[r][c] = 1'b1;
    wait_clk(hold);
    keys[r][c] = 1'b0;
    wait_clk(gap);
    shift = 0; ctrl = 0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog all R actual=running expected=finished");
      report();
    end
  end

  initial begin
    logic [7:0] d;
    logic       i;
    bit         seen;
    for (int r = 0; r < 8; r++) keys[r] = 8'h00;
    wait_clk(4);
    rst_n = 1;
    wait_clk(1);
    // R1: reset state
    cmp("R1", "scan_o after reset", {4'h0, scan}, 8'h00);
    cmp("R1", "irq after reset", {7'h0, irq}, 8'h00);
    bus_rd(1, d, i);
    cmp("R1", "status after reset", d, 8'h00);

    bus_wr(0, 8'd1);  // R11: prescaler = 1
    // R5 R2: single key row 5 col 2 with shift
    press(5, 2, 1, 0, 70, 40);
    bus_rd(1, d, i);
    cmp("R8", "status one key", d, 8'h01);
    bus_rd(1, d, i);
    cmp("R8", "status re-read keeps count", d, 8'h01);
    cmp("R10", "irq with entry", {7'h0, irq}, 8'h01);
    bus_rd(0, d, i);
    cmp("R5", "code row5 col2 shift", d, 8'h6A);
    cmp("R10", "irq during data read", {7'h0, i}, 8'h00);
    wait_clk(1);
    cmp("R10", "irq after last read", {7'h0, irq}, 8'h00);

    // R4: closure shorter than the debounce window
    @(negedge clk); keys[3][4] = 1'b1;
    wait_clk(6); keys[3][4] = 1'b0;
    wait_clk(60);
    bus_rd(1, d, i);
    cmp("R4", "short press not stored", d, 8'h00);

    // R6: long hold stores once
    press(1, 7, 0, 1, 300, 40);
    bus_rd(1, d, i);
    cmp("R6", "long hold count", d, 8'h01);
    bus_rd(0, d, i);
    cmp("R5", "code row1 col7 ctrl", d, 8'h8F);

    // R5: lowest column wins
    @(negedge clk); keys[6] = 8'b0100_0010;
    wait_clk(70); keys[6] = 8'h00;
    wait_clk(40);
    bus_rd(0, d, i);
    cmp("R5", "lowest column of row 6", d, 8'h31);

    // R7: order of three keys
    press(0, 0, 0, 0, 70, 40);
    press(7, 7, 0, 0, 70, 40);
    press(4, 3, 0, 0, 70, 40);
    bus_rd(0, d, i);
    cmp("R7", "first key", d, 8'h00);
    cmp("R10", "irq low in read", {7'h0, i}, 8'h00);
    wait_clk(1);
    cmp("R10", "irq back after read", {7'h0, irq}, 8'h01);
    bus_rd(0, d, i);
    cmp("R7", "second key", d, 8'h3F);
    bus_rd(0, d, i);
    cmp("R7", "third key", d, 8'h23);

    // R11: unselected write ignored, binary scan continues
    bus_wr(1, 8'h01, 0);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      wait_clk(1);
      if (scan == 4'd3) seen = 1;
    end
    cmp("R11", "unselected write keeps binary mode", {7'h0, seen}, 8'h01);

    // R3: one-hot mode
    bus_wr(1, 8'h01);
    kb_dec = 1;
    cmp("R3", "one-hot restart at line 0", {4'h0, scan}, 8'h01);
    press(2, 7, 0, 1, 50, 30);
    bus_rd(0, d, i);
    cmp("R3", "one-hot code row2 col7 ctrl", d, 8'h97);

    // R9: overrun after 8 entries
    for (int k = 0; k < 9; k++) press(k % 4, k / 4, 0, 0, 50, 30);
    bus_rd(1, d, i);
    cmp("R9", "full with overrun", d, 8'h28);
    for (int k = 0; k < 8; k++) begin
      bus_rd(0, d, i);
      cmp("R9", "entry kept in order", d, {2'b00, 3'(k % 4), 3'(k / 4)});
    end
    bus_rd(1, d, i);
    cmp("R9", "overrun sticky when empty", d, 8'h20);
    bus_wr(1, 8'h81);
    bus_rd(1, d, i);
    cmp("R9", "overrun cleared", d, 8'h00);

    // R12: empty read
    bus_rd(0, d, i);
    cmp("R12", "empty data read", d, 8'h00);
    bus_rd(1, d, i);
    cmp("R12", "count stays zero", d, 8'h00);

    wait_clk(4);
    done = 1;
    report();
  end
endmodule